// File: doc/BRIEF.md
# Bit Scan and Count Unit

This execution unit takes a 32-bit or 64-bit source operand and computes one of four bit-position results. The four results are: the position of the lowest set bit, the position of the highest set bit, the count of zeros above the highest set bit, and the count of zeros below the lowest set bit. The current contents of the destination register arrive alongside the source. When a scan finds no set bit, the unit hands that old value back unchanged.

The unit accepts one operation per cycle under a valid strobe. It produces a registered 64-bit destination value and a zero flag one cycle later. The latency is fixed and does not depend on the data, because both bit positions come from parallel priority encoders. The two scan operations treat an all-zero source as "no answer": they set the flag and preserve every bit of the old destination, even in 32-bit mode. The two count operations stay well defined for a zero source and return the operand width.

Top module: `bitscan_unit`

## Requirements
- R1: With op = 2'b00 (forward scan) and a non-zero effective source, dst becomes the bit index of the lowest set bit, zero-extended to 64 bits, and zf = 0.
- R2: With op = 2'b01 (reverse scan) and a non-zero effective source, dst becomes the bit index of the highest set bit, zero-extended to 64 bits, and zf = 0.
- R3: With op = 2'b00 or 2'b01 and an all-zero effective source, dst takes all 64 bits of old_dst unchanged and zf = 1. This holds in both operand sizes, with no clearing of the upper half in 32-bit mode.
- R4: With wide = 0 (32-bit mode), only src[31:0] is examined and src[63:32] has no effect. Every result written from a non-zero source or by a count operation has dst[63:32] = 0.
- R5: With op = 2'b10 (leading-zero count), dst is the number of zero bits above the highest set bit within the operand width. For a zero source dst is the width: 32 when wide = 0, 64 when wide = 1. In 32-bit mode a non-zero source gives a count equal to the highest-set-bit index XOR 31.
- R6: With op = 2'b11 (trailing-zero count), dst equals the forward-scan index for every non-zero source. For a zero source dst is the operand width.
- R7: For the count operations, zf = 1 exactly when the count written is 0. For the scan operations, zf = 1 exactly when the effective source is zero.
- R8: out_valid rises on the clock edge after the edge that accepts in_valid = 1. When in_valid = 0, out_valid falls and dst and zf hold their previous values whatever the other inputs do.
- R9: While rst_n is low, out_valid = 0, dst = 0 and zf = 0.
- R10: When the effective source has exactly one set bit, forward scan and reverse scan write the same index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request in this cycle |
| op | input | 2 | 00 forward scan, 01 reverse scan, 10 leading-zero count, 11 trailing-zero count |
| wide | input | 1 | 1 for 64-bit operand, 0 for 32-bit operand |
| src | input | 64 | Source operand |
| old_dst | input | 64 | Current destination register value, sampled with src |
| out_valid | output | 1 | Result registered this cycle |
| dst | output | 64 | New destination value |
| zf | output | 1 | Zero flag |

## Verification
The assertions assume that old_dst, op, wide and src are stable and meaningful only in cycles where in_valid is high. They also assume that a result must be taken in the cycle it appears, because nothing at the output can apply back-pressure. The stimulus drives inputs only on falling edges. It deliberately changes every data input during idle cycles, which exercises the hold behaviour. It puts random data in the upper half of src during 32-bit operations. It mixes all-zero, single-bit and dense sources so that the zero-source, one-hot and general paths each occur under every operation and both sizes.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    OP_FWD = 2'b00,
    OP_REV = 2'b01,
    OP_LZC = 2'b10,
    OP_TZC = 2'b11
  } bsu_op_e;

  // Index/count width large enough for operands up to 128 bits.
  localparam int unsigned CNT_W = 8;

  function automatic logic [CNT_W-1:0] lanes(input logic wide_i,
                                             input logic [CNT_W-1:0] full_w);
    return wide_i ? full_w : (full_w >> 1);
  endfunction

  // Zeros above the highest set bit, given that bit's index.
  function automatic logic [CNT_W-1:0] lead_zeros(input logic [CNT_W-1:0] width_i,
                                                  input logic [CNT_W-1:0] hi_i);
    return width_i - 8'd1 - hi_i;
  endfunction

  function automatic logic is_scan(input bsu_op_e op_i);
    return (op_i == OP_FWD) || (op_i == OP_REV);
  endfunction

endpackage

// File: rtl/bsu_locator.sv
module bsu_locator #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = 8
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] lo_idx,
  output logic [IW-1:0] hi_idx,
  output logic          any_set
);

  // Two parallel priority encoders: every bit is examined in the same cycle.
  always_comb begin
    lo_idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) lo_idx = IW'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) hi_idx = IW'(i);
    end
  end

  assign any_set = |vec;

endmodule

// File: rtl/bsu_result.sv
module bsu_result
  import bsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  bsu_op_e           op,
  input  logic              wide,
  input  logic              any_set,
  input  logic [CNT_W-1:0]  lo_idx,
  input  logic [CNT_W-1:0]  hi_idx,
  input  logic [DATA_W-1:0] old_dst,
  output logic [DATA_W-1:0] res,
  output logic              res_zf
);

  localparam logic [CNT_W-1:0] FULL_W = CNT_W'(DATA_W);

  logic [CNT_W-1:0] width_n;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    width_n = lanes(wide, FULL_W);
    cnt     = '0;
    res     = '0;
    res_zf  = 1'b0;
    unique case (op)
      OP_FWD: begin
        res    = any_set ? DATA_W'(lo_idx) : old_dst;
        res_zf = !any_set;
      end
      OP_REV: begin
        res    = any_set ? DATA_W'(hi_idx) : old_dst;
        res_zf = !any_set;
      end
      OP_LZC: begin
        cnt    = any_set ? lead_zeros(width_n, hi_idx) : width_n;
        res    = DATA_W'(cnt);
        res_zf = (cnt == '0);
      end
      OP_TZC: begin
        cnt    = any_set ? lo_idx : width_n;
        res    = DATA_W'(cnt);
        res_zf = (cnt == '0);
      end
      default: begin
        res    = old_dst;
        res_zf = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
  import bsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] old_dst,
  output logic              out_valid,
  output logic [DATA_W-1:0] dst,
  output logic              zf
);

  localparam int unsigned HALF_W = DATA_W / 2;

  // Named internal events for the checker.
  logic [DATA_W-1:0] src_eff;
  logic              src_zero;
  logic [CNT_W-1:0]  lo_idx;
  logic [CNT_W-1:0]  hi_idx;
  logic              any_set;
  logic [DATA_W-1:0] res;
  logic              res_zf;
  bsu_op_e           op_e;

  assign op_e     = bsu_op_e'(op);
  assign src_eff  = wide ? src : {{HALF_W{1'b0}}, src[HALF_W-1:0]};
  assign src_zero = !any_set;

  bsu_locator #(.W(DATA_W), .IW(CNT_W)) u_loc (
    .vec     (src_eff),
    .lo_idx  (lo_idx),
    .hi_idx  (hi_idx),
    .any_set (any_set)
  );

  bsu_result #(.DATA_W(DATA_W)) u_res (
    .op      (op_e),
    .wide    (wide),
    .any_set (any_set),
    .lo_idx  (lo_idx),
    .hi_idx  (hi_idx),
    .old_dst (old_dst),
    .res     (res),
    .res_zf  (res_zf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dst       <= '0;
      zf        <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst <= res;
        zf  <= res_zf;
      end
    end
  end

endmodule

// File: rtl/bsu_checker.sv
module bsu_checker #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned IW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        op,
  input logic              wide,
  input logic [DATA_W-1:0] src_eff,
  input logic              src_zero,
  input logic [IW-1:0]     lo_idx,
  input logic [IW-1:0]     hi_idx,
  input logic [DATA_W-1:0] old_dst,
  input logic              out_valid,
  input logic [DATA_W-1:0] dst,
  input logic              zf
);

  localparam logic [DATA_W-1:0] FULL_CNT = DATA_W'(DATA_W);
  localparam logic [DATA_W-1:0] HALF_CNT = DATA_W'(DATA_W / 2);

  logic is_scan;
  assign is_scan = !op[1];

  AST_SCAN_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_scan && src_zero |=> (dst == $past(old_dst)) && zf); // R3

  AST_SCAN_NONZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_scan && !src_zero |=> !zf); // R7

  AST_NARROW_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !wide && !(is_scan && src_zero) |=> dst[DATA_W-1:DATA_W/2] == '0); // R4

  AST_LZC_ZERO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'b10 && src_zero && wide |=> dst == FULL_CNT); // R5

  AST_TZC_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == 2'b11 && src_zero && !wide |=> dst == HALF_CNT); // R6

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(dst) && $stable(zf)); // R8

  AST_ONE_HOT_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(src_eff) == 1 |-> lo_idx == hi_idx); // R10

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> !out_valid && dst == '0 && !zf); // R9

endmodule

bind bitscan_unit bsu_checker #(.DATA_W(DATA_W), .IW(bsu_pkg::CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .wide      (wide),
  .src_eff   (src_eff),
  .src_zero  (src_zero),
  .lo_idx    (lo_idx),
  .hi_idx    (hi_idx),
  .old_dst   (old_dst),
  .out_valid (out_valid),
  .dst       (dst),
  .zf        (zf)
);

// File: tb/tb_bitscan_unit.sv
module tb_bitscan_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic        wide = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] old_dst = '0;
  logic        out_valid;
  logic [63:0] dst;
  logic        zf;

  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // Reference model state: what the outputs must show after the next edge.
  logic        exp_v = 1'b0;
  logic [63:0] exp_d = '0;
  logic        exp_z = 1'b0;
  string       exp_tag = "R9";

  always #4 clk = ~clk;

  bitscan_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .wide(wide),
    .src(src), .old_dst(old_dst), .out_valid(out_valid), .dst(dst), .zf(zf)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Behavioural reference: walk inward from each end counting zeros.
  task automatic reference(input logic [1:0] o, input logic w, input logic [63:0] s,
                           input logic [63:0] od, output logic [63:0] d,
                           output logic z, output string tag);
    int width = w ? 64 : 32;
    int tz = 0;
    int lz = 0;
    while (tz < width && s[tz] == 1'b0) tz++;
    while (lz < width && s[width - 1 - lz] == 1'b0) lz++;
    case (o)
      2'b00: begin
        if (tz == width) begin d = od; z = 1'b1; tag = "R3"; end
        else begin d = 64'(tz); z = 1'b0; tag = "R1"; end
      end
      2'b01: begin
        if (lz == width) begin d = od; z = 1'b1; tag = "R3"; end
        else begin d = 64'(width - 1 - lz); z = 1'b0; tag = "R2"; end
      end
      2'b10: begin d = 64'(lz); z = (lz == 0); tag = "R5/R7"; end
      default: begin d = 64'(tz); z = (tz == 0); tag = "R6/R7"; end
    endcase
    if (!w) tag = {tag, "/R4"};
  endtask

  // At a falling edge: compare, then drive the next cycle and advance the model.
  task automatic step(input logic v, input logic [1:0] o, input logic w,
                      input logic [63:0] s, input logic [63:0] od);
    logic [63:0] d;
    logic        z;
    string       t;
    check({exp_tag, "/R8 valid"}, 64'(out_valid), 64'(exp_v));
    check({exp_tag, " dst"}, dst, exp_d);
    check({exp_tag, " zf"}, 64'(zf), 64'(exp_z));
    in_valid = v; op = o; wide = w; src = s; old_dst = od;
    exp_v = v;
    if (v) begin
      reference(o, w, s, od, d, z, t);
      exp_d = d; exp_z = z; exp_tag = t;
    end else begin
      exp_tag = "R8 hold";
    end
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] r;
    repeat (3) @(negedge clk);
    check("R9 valid", 64'(out_valid), 64'd0);
    check("R9 dst", dst, 64'd0);
    check("R9 zf", 64'(zf), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed cases
    step(1, 2'b00, 1, 64'h0000_0100_0000_0010, 64'hDEAD); // R1 -> 4
    step(1, 2'b01, 1, 64'h0000_0100_0000_0010, 64'hDEAD); // R2 -> 40
    step(1, 2'b00, 1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);     // R3 keep
    step(1, 2'b01, 0, 64'hABCD_0000_0000_0000, 64'hFFFF_FFFF_1234_5678); // R3 R4 narrow keep
    step(1, 2'b00, 0, 64'hFFFF_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF); // R4 -> 31, upper zero
    step(1, 2'b10, 1, 64'h0, 64'h55);                      // R5 -> 64
    step(1, 2'b10, 0, 64'hFFFF_FFFF_0000_0000, 64'h55);    // R5 -> 32
    step(1, 2'b10, 0, 64'h0000_0000_0000_0100, 64'h55);    // R5 -> 23 = 8^31
    step(1, 2'b10, 1, 64'h8000_0000_0000_0000, 64'h55);    // R7 count 0 -> zf
    step(1, 2'b11, 1, 64'h0, 64'h55);                      // R6 -> 64
    step(1, 2'b11, 0, 64'h1234_5678_0000_0000, 64'h55);    // R6 -> 32
    step(1, 2'b11, 1, 64'h0000_0000_0000_0001, 64'h55);    // R6 R7 -> 0 zf
    step(1, 2'b11, 1, 64'h0400_0000_0000_0000, 64'h55);    // R6 -> 58
    step(1, 2'b00, 1, 64'h0000_2000_0000_0000, 64'h0);     // R10 fwd 45
    step(1, 2'b01, 1, 64'h0000_2000_0000_0000, 64'h0);     // R10 rev 45
    step(0, 2'b10, 1, 64'hFFFF, 64'h9999);                 // R8 idle, inputs changed
    step(0, 2'b00, 0, 64'h0, 64'h7777);                    // R8 idle
    step(1, 2'b00, 1, 64'h0000_0000_0000_0001, 64'h1);     // R1 -> 0, zf 0
    step(1, 2'b01, 0, 64'h0000_0000_FFFF_FFFF, 64'h1);     // R2 -> 31

    // Mixed pseudo-random traffic
    for (int i = 0; i < 2000; i++) begin
      int kind = $urandom_range(0, 3);
      r = {$urandom, $urandom};
      if (kind == 0) r = '0;
      else if (kind == 1) r = 64'h1 << $urandom_range(0, 63);
      else if (kind == 2) r = r & {$urandom, $urandom};
      step(1'($urandom_range(0, 4) != 0), 2'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), r, {$urandom, $urandom});
    end
    step(0, 2'b00, 0, 64'h0, 64'h0);
    step(0, 2'b00, 0, 64'h0, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1'b1;
    $finish;
  end

endmodule